// File: doc/BRIEF.md
# Address-Compressing Command Frame Encoder

This block turns one command request into a serial frame for a two-wire clocked link to a small set of slaves. An access request carries a 2-bit slave id, a 21-bit byte address, a transfer size, a read/write flag and up to four write-data bytes. The block remembers the word address of the last access that completed without error. It uses that record to pick the shortest of three address forms:

- a 2-bit same-word form,
- a 9-bit signed offset form,
- a full 21-bit absolute form.

Three short link commands can also be requested: a poll for a busy slave, a poll after an error, and a terminate.

Each frame ends with a 4-bit CRC. The frame appears one clock after the request as a 64-bit word, left-aligned so that the first bit to send is bit 63, together with its length in bits. A serializer further along the path shifts it onto the wire. The response path reports every outcome on the update port. A completed access loads the address record. A failed access, a terminate or a link reset clears it.

Top module: `fcenc_frame_encoder`

## Requirements
- R1: After reset `frm_valid`, `frm_bits` and `frm_len` are zero and no address is remembered. A request with `req_valid` high produces `frm_valid` high for exactly the next clock cycle, with `frm_bits`/`frm_len` for that request.
- R2: An access frame is made of the following fields, sent most significant bit first: id (2 bits), opcode, direction bit (1 = read, 0 = write), address field, size flag, then write data. With no usable record the absolute form is used: opcode 3'b100 and all 21 address bits. A read in this form is 32 bits long.
- R3: When the record is valid and holds the same id and the same word address (byte address with bits 1:0 cleared), the same-word form is used. It has the 2-bit opcode 2'b11 and only the two coded low address bits. A read in this form is 12 bits long.
- R4: When the record is valid and holds the same id, and the byte address minus the remembered word address lies in -256..+255, the offset form is used. It has opcode 3'b101 and a 9-bit two's-complement offset whose low 2 bits are the coded low address bits. A read in this form is 20 bits long.
- R5: An offset outside -256..+255, or a different id, selects the absolute form. The same-word form has priority over the offset form.
- R6: Size coding works as follows. `req_size` 4 gives size flag 1 with address bits 1:0 sent as 2'b01. `req_size` 2 gives size flag 1 with address bit 0 sent as 0. Any other value is treated as a single byte: size flag 0 and the address bits are sent unchanged.
- R7: A write appends the low 8×size bits of `req_wdata`, most significant bit first. A read appends no data.
- R8: The busy poll is id followed by 3'b010. The error poll is id followed by 3'b011. Terminate is id followed by 6'b111111. Their frame lengths are 9, 9 and 12 bits.
- R9: The last 4 frame bits are a CRC with polynomial x^4+x+1 and initial value zero. It is computed over a leading 1 followed by every preceding frame bit in send order. All bits of `frm_bits` below the frame are zero.
- R10: `upd_valid` with `upd_ok` high records `upd_id` and the word address of `upd_addr`. With `upd_ok` low it clears the record. A request in the same cycle as an update is encoded against the record held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Encode a command this cycle |
| req_kind | input | 2 | 0 access, 1 busy poll, 2 error poll, 3 terminate |
| req_id | input | 2 | Slave id |
| req_addr | input | 21 | Byte address of an access |
| req_size | input | 3 | Transfer size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, low 8×size bits used |
| upd_valid | input | 1 | Outcome report for the last access |
| upd_ok | input | 1 | 1 completed, 0 failed/terminate/link reset |
| upd_id | input | 2 | Id of the completed access |
| upd_addr | input | 21 | Byte address of the completed access |
| frm_valid | output | 1 | Frame ready, one cycle |
| frm_bits | output | 64 | Frame, first bit at bit 63 |
| frm_len | output | 7 | Frame length in bits |

## Verification
The hardest cases to reach are the offset-form limits. There the choice hinges on a single step of address difference: +255 against +256, and -256 against -257. The id must match and the record must be valid at the same time. The stimulus loads a chosen word address through the update port. It then places requests exactly at and one step past each limit, and checks the opcode field and the 9-bit offset field directly. A request issued in the same cycle as an invalidating update shows that the old record still decides that frame.

// File: rtl/fcenc_pkg.sv
// Shared sizes, command kinds and address-form types for the frame encoder.
package fcenc_pkg;
    localparam int ID_W      = 2;
    localparam int ADDR_W    = 21;
    localparam int REL_W     = 9;
    localparam int MAX_BYTES = 4;
    localparam int CRC_W     = 4;
    localparam int OPC_W     = 3;
    localparam int TERM_W    = 6;
    localparam int FRAME_W   = ID_W + OPC_W + 1 + ADDR_W + 1 + 8 * MAX_BYTES + CRC_W;
    localparam int BODY_W    = FRAME_W - CRC_W;
    localparam int LEN_W     = $clog2(FRAME_W + 1);
    localparam int HIST_W    = ID_W + ADDR_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

    typedef enum logic [1:0] {
        KIND_ACCESS = 2'd0,
        KIND_DPOLL  = 2'd1,
        KIND_EPOLL  = 2'd2,
        KIND_TERM   = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        FORM_ABS  = 2'd0,
        FORM_REL  = 2'd1,
        FORM_SAME = 2'd2
    } addr_form_e;

    typedef struct packed {
        addr_form_e        form;
        logic [OPC_W-1:0]  opc;
        logic [LEN_W-1:0]  opc_w;
        logic [ADDR_W-1:0] afield;
        logic [LEN_W-1:0]  afield_w;
        logic              ds;
        logic [LEN_W-1:0]  data_w;
    } form_t;

    // Append the low w bits of val below the bits already in acc.
    function automatic logic [BODY_W-1:0] push_bits(
        input logic [BODY_W-1:0] acc,
        input logic [BODY_W-1:0] val,
        input logic [LEN_W-1:0]  w
    );
        logic [BODY_W-1:0] mask;
        mask = (int'(w) >= BODY_W) ? '1 : ((BODY_W'(1) << w) - BODY_W'(1));
        return (acc << w) | (val & mask);
    endfunction
endpackage

// File: rtl/fcenc_addr_history.sv
// Remembers id and word address of the last completed access.
// Assumes: update reports arrive on upd_valid; a failure, terminate or link
// reset is reported with upd_ok low. Stored value 1 marks "no record", which
// no word-aligned entry can equal.
module fcenc_addr_history
    import fcenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic              upd_ok,
    input  logic [ID_W-1:0]   upd_id,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic              hist_valid,
    output logic [ID_W-1:0]   hist_id,
    output logic [ADDR_W-1:0] hist_word
);
    localparam logic [HIST_W-1:0] NO_RECORD = HIST_W'(1);

    logic [HIST_W-1:0] hist_q;

    // Load the record on success, clear it on any other outcome or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= NO_RECORD;
        end else if (upd_valid) begin
            if (upd_ok) begin
                hist_q <= {upd_id, upd_addr[ADDR_W-1:2], 2'b00};
            end else begin
                hist_q <= NO_RECORD;
            end
        end
    end

    // Split the record into its fields.
    always_comb begin
        hist_valid = (hist_q != NO_RECORD);
        hist_id    = hist_q[HIST_W-1 -: ID_W];
        hist_word  = hist_q[ADDR_W-1:0];
    end

    // R10
    invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ok) |=> !hist_valid);

    // R10
    record_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ok) |=> (hist_valid && hist_id == $past(upd_id)));
endmodule

// File: rtl/fcenc_form_select.sv
// Chooses same-word, offset or absolute addressing for an access and
// produces the opcode, the coded address field and the size flag.
// Assumes: accesses are naturally aligned, so the low address bits are
// free to carry the size code. Purely combinational; clk/rst_n only clock
// the checks.
module fcenc_form_select
    import fcenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic              hist_valid,
    input  logic [ID_W-1:0]   hist_id,
    input  logic [ADDR_W-1:0] hist_word,
    output form_t             sel
);
    localparam logic signed [ADDR_W:0] REL_LO = -(ADDR_W+1)'(2 ** (REL_W - 1));
    localparam logic signed [ADDR_W:0] REL_HI = (ADDR_W+1)'(2 ** (REL_W - 1) - 1);

    logic [ADDR_W-1:0]        coded;
    logic [ADDR_W-1:0]        word;
    logic [LEN_W-1:0]         nbytes;
    logic signed [ADDR_W:0]   diff;
    logic                     id_match;
    logic                     same_hit;
    logic                     rel_hit;
    logic [REL_W-1:0]         rel_field;

    // Size decode and low-address size coding.
    always_comb begin
        unique case (size)
            3'd4: begin
                nbytes = LEN_W'(4);
                coded  = {addr[ADDR_W-1:2], 2'b01};
            end
            3'd2: begin
                nbytes = LEN_W'(2);
                coded  = {addr[ADDR_W-1:1], 1'b0};
            end
            default: begin
                nbytes = LEN_W'(1);
                coded  = addr;
            end
        endcase
        word = {addr[ADDR_W-1:2], 2'b00};
    end

    // Compare the request with the remembered address.
    always_comb begin
        id_match  = hist_valid && (hist_id == id);
        diff      = $signed({1'b0, addr}) - $signed({1'b0, hist_word});
        same_hit  = id_match && (hist_word == word);
        rel_hit   = id_match && (diff >= REL_LO) && (diff <= REL_HI);
        rel_field = {diff[REL_W-1:2], coded[1:0]};
    end

    // Pick the shortest form; same-word wins over offset.
    always_comb begin
        sel.ds     = (nbytes != LEN_W'(1));
        sel.data_w = LEN_W'(8) * nbytes;
        if (same_hit) begin
            sel.form     = FORM_SAME;
            sel.opc      = 3'b011;
            sel.opc_w    = LEN_W'(2);
            sel.afield   = ADDR_W'(coded[1:0]);
            sel.afield_w = LEN_W'(2);
        end else if (rel_hit) begin
            sel.form     = FORM_REL;
            sel.opc      = 3'b101;
            sel.opc_w    = LEN_W'(OPC_W);
            sel.afield   = ADDR_W'(rel_field);
            sel.afield_w = LEN_W'(REL_W);
        end else begin
            sel.form     = FORM_ABS;
            sel.opc      = 3'b100;
            sel.opc_w    = LEN_W'(OPC_W);
            sel.afield   = coded;
            sel.afield_w = LEN_W'(ADDR_W);
        end
    end

    // R3
    same_needs_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.form == FORM_SAME) |-> (hist_valid && hist_id == id));

    // R5
    offset_needs_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.form == FORM_REL) |-> (hist_valid && hist_id == id));
endmodule

// File: rtl/fcenc_crc.sv
// Serial-equivalent 4-bit CRC over a start bit of 1 followed by the low
// len bits of msg, most significant of them first.
// Assumes: len never exceeds DATA_W; bits of msg above len are ignored.
module fcenc_crc
    import fcenc_pkg::*;
#(
    parameter int DATA_W = BODY_W
) (
    input  logic [DATA_W-1:0] msg,
    input  logic [LEN_W-1:0]  len,
    output logic [CRC_W-1:0]  crc
);
    // One shift step of the CRC register for one input bit.
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] c,
        input logic             b
    );
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // Unrolled walk over every possible frame bit.
    always_comb begin
        crc = crc_step('0, 1'b1);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (i < int'(len)) begin
                crc = crc_step(crc, msg[i]);
            end
        end
    end
endmodule

// File: rtl/fcenc_frame_encoder.sv
// Top of the command frame encoder: assembles access or link-command
// frames, appends the CRC and registers the left-aligned result.
// Assumes: one request per cycle at most; the consumer samples the frame
// in the single cycle frm_valid is high.
module fcenc_frame_encoder
    import fcenc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [ID_W-1:0]      req_id,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_size,
    input  logic                 req_write,
    input  logic [8*MAX_BYTES-1:0] req_wdata,
    input  logic                 upd_valid,
    input  logic                 upd_ok,
    input  logic [ID_W-1:0]      upd_id,
    input  logic [ADDR_W-1:0]    upd_addr,
    output logic                 frm_valid,
    output logic [FRAME_W-1:0]   frm_bits,
    output logic [LEN_W-1:0]     frm_len
);
    logic              hist_valid;
    logic [ID_W-1:0]   hist_id;
    logic [ADDR_W-1:0] hist_word;
    form_t             sel;
    logic [BODY_W-1:0] body;
    logic [LEN_W-1:0]  body_len;
    logic [CRC_W-1:0]  crc;
    logic [FRAME_W-1:0] full;
    logic [LEN_W-1:0]  total_len;
    logic [FRAME_W-1:0] aligned;
    cmd_kind_e         kind;

    fcenc_addr_history u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (upd_valid),
        .upd_ok     (upd_ok),
        .upd_id     (upd_id),
        .upd_addr   (upd_addr),
        .hist_valid (hist_valid),
        .hist_id    (hist_id),
        .hist_word  (hist_word)
    );

    fcenc_form_select u_form (
        .clk        (clk),
        .rst_n      (rst_n),
        .id         (req_id),
        .addr       (req_addr),
        .size       (req_size),
        .hist_valid (hist_valid),
        .hist_id    (hist_id),
        .hist_word  (hist_word),
        .sel        (sel)
    );

    // Build the frame body, right-aligned, field by field.
    always_comb begin
        kind     = cmd_kind_e'(req_kind);
        body     = '0;
        body_len = '0;
        body     = push_bits(body, BODY_W'(req_id), LEN_W'(ID_W));
        body_len = body_len + LEN_W'(ID_W);
        unique case (kind)
            KIND_ACCESS: begin
                body     = push_bits(body, BODY_W'(sel.opc), sel.opc_w);
                body     = push_bits(body, BODY_W'(!req_write), LEN_W'(1));
                body     = push_bits(body, BODY_W'(sel.afield), sel.afield_w);
                body     = push_bits(body, BODY_W'(sel.ds), LEN_W'(1));
                body_len = body_len + sel.opc_w + sel.afield_w + LEN_W'(2);
                if (req_write) begin
                    body     = push_bits(body, BODY_W'(req_wdata), sel.data_w);
                    body_len = body_len + sel.data_w;
                end
            end
            KIND_DPOLL: begin
                body     = push_bits(body, BODY_W'(3'b010), LEN_W'(OPC_W));
                body_len = body_len + LEN_W'(OPC_W);
            end
            KIND_EPOLL: begin
                body     = push_bits(body, BODY_W'(3'b011), LEN_W'(OPC_W));
                body_len = body_len + LEN_W'(OPC_W);
            end
            default: begin
                body     = push_bits(body, BODY_W'({TERM_W{1'b1}}), LEN_W'(TERM_W));
                body_len = body_len + LEN_W'(TERM_W);
            end
        endcase
    end

    fcenc_crc #(
        .DATA_W (BODY_W)
    ) u_crc (
        .msg (body),
        .len (body_len),
        .crc (crc)
    );

    // Append the CRC and move the first bit to the top.
    always_comb begin
        full      = {body, crc};
        total_len = body_len + LEN_W'(CRC_W);
        aligned   = full << (LEN_W'(FRAME_W) - total_len);
    end

    // Register the frame for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_valid <= 1'b0;
            frm_bits  <= '0;
            frm_len   <= '0;
        end else begin
            frm_valid <= req_valid;
            if (req_valid) begin
                frm_bits <= aligned;
                frm_len  <= total_len;
            end
        end
    end

    // R1
    frame_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> frm_valid);

    // R1
    no_spurious_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !frm_valid);

    // R9
    tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> ((frm_bits << frm_len) == '0));

    // R8
    term_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> (frm_len == LEN_W'(12)));

    // R2
    length_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (frm_len >= LEN_W'(9) && frm_len <= LEN_W'(FRAME_W)));
endmodule

// File: tb/fcenc_frame_encoder_test.sv
`timescale 1ns/1ps
module fcenc_frame_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_id = '0;
    logic [20:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        upd_valid = 1'b0;
    logic        upd_ok = 1'b0;
    logic [1:0]  upd_id = '0;
    logic [20:0] upd_addr = '0;
    logic        frm_valid;
    logic [63:0] frm_bits;
    logic [6:0]  frm_len;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference record of the last completed access
    bit          m_valid = 0;
    logic [1:0]  m_id = '0;
    logic [20:0] m_word = '0;
    // expected frame being built
    logic [63:0] e_bits;
    int          e_len;

    fcenc_frame_encoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_id(req_id), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata), .upd_valid(upd_valid),
        .upd_ok(upd_ok), .upd_id(upd_id), .upd_addr(upd_addr),
        .frm_valid(frm_valid), .frm_bits(frm_bits), .frm_len(frm_len)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add(input logic [31:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            e_bits[63 - e_len] = v[k];
            e_len++;
        end
    endtask

    // Expected frame straight from the field rules.
    task automatic model_frame(input logic [1:0] kind, input logic [1:0] id,
                               input logic [20:0] addr, input logic [2:0] size,
                               input logic wr, input logic [31:0] wd);
        int nb;
        int d;
        logic [1:0] lo;
        logic [3:0] c;
        logic fb;
        e_bits = '0;
        e_len = 0;
        nb = (size == 3'd4) ? 4 : (size == 3'd2) ? 2 : 1;
        lo = (nb == 4) ? 2'b01 : (nb == 2) ? {addr[1], 1'b0} : addr[1:0];
        add(32'(id), 2);
        if (kind == 2'd0) begin
            d = int'(addr) - int'(m_word);
            if (m_valid && m_id == id && m_word == {addr[20:2], 2'b00}) begin
                add(32'd3, 2); add(32'(!wr), 1); add(32'(lo), 2);
            end else if (m_valid && m_id == id && d >= -256 && d <= 255) begin
                add(32'd5, 3); add(32'(!wr), 1);
                add((32'(d) & 32'h1FC) | 32'(lo), 9);
            end else begin
                add(32'd4, 3); add(32'(!wr), 1);
                add(32'({addr[20:2], lo}), 21);
            end
            add(32'(nb != 1), 1);
            if (wr) for (int b = nb - 1; b >= 0; b--) add(32'(wd[8*b +: 8]), 8);
        end else if (kind == 2'd1) add(32'd2, 3);
        else if (kind == 2'd2) add(32'd3, 3);
        else add(32'h3F, 6);
        c = 4'd0;
        for (int k = -1; k < e_len; k++) begin
            fb = c[3] ^ ((k < 0) ? 1'b1 : e_bits[63 - k]);
            c = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
        end
        add(32'(c), 4);
    endtask

    // Issue one request; compare frame with the reference one cycle later.
    task automatic send(input logic [1:0] kind, input logic [1:0] id,
                        input logic [20:0] addr, input logic [2:0] size,
                        input logic wr, input logic [31:0] wd, input string tag);
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_id = id; req_addr = addr;
        req_size = size; req_write = wr; req_wdata = wd;
        model_frame(kind, id, addr, size, wr, wd);
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, 64'(frm_valid), 64'd1);
        chk({tag, " len"}, 64'(frm_len), 64'(e_len));
        chk({tag, " bits"}, frm_bits, e_bits);
    endtask

    task automatic update(input logic ok, input logic [1:0] id, input logic [20:0] addr);
        @(negedge clk);
        upd_valid = 1; upd_ok = ok; upd_id = id; upd_addr = addr;
        @(negedge clk);
        upd_valid = 0;
        m_valid = ok; m_id = id; m_word = {addr[20:2], 2'b00};
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset valid", 64'(frm_valid), 64'd0);
        chk("R1 reset bits", frm_bits, 64'd0);
        chk("R1 reset len", 64'(frm_len), 64'd0);
    endtask

    task automatic t_absolute;
        send(2'd0, 2'd1, 21'h12345, 3'd4, 1'b0, 32'h0, "R2 abs read");
        chk("R2 abs len", 64'(frm_len), 64'd32);
        chk("R2 abs id", 64'(frm_bits[63:62]), 64'd1);
        chk("R2 abs opcode", 64'(frm_bits[61:59]), 64'd4);
        chk("R2 abs dir", 64'(frm_bits[58]), 64'd1);
        @(negedge clk);
        chk("R1 one-cycle pulse", 64'(frm_valid), 64'd0);
    endtask

    task automatic t_same;
        update(1'b1, 2'd1, 21'h12345);
        send(2'd0, 2'd1, 21'h12346, 3'd1, 1'b0, 32'h0, "R3 same read");
        chk("R3 same len", 64'(frm_len), 64'd12);
        chk("R3 same opcode", 64'(frm_bits[61:60]), 64'd3);
        chk("R3 same offset", 64'(frm_bits[58:57]), 64'd2);
        chk("R10 record used", 64'(frm_len), 64'd12);
    endtask

    task automatic t_offset_limits;
        update(1'b1, 2'd0, 21'h00100);
        send(2'd0, 2'd0, 21'h001FF, 3'd1, 1'b0, 32'h0, "R4 offset +255");
        chk("R4 +255 opcode", 64'(frm_bits[61:59]), 64'd5);
        chk("R4 +255 field", 64'(frm_bits[57:49]), 64'h0FF);
        chk("R4 +255 len", 64'(frm_len), 64'd20);
        send(2'd0, 2'd0, 21'h00200, 3'd1, 1'b0, 32'h0, "R5 offset +256");
        chk("R5 +256 opcode", 64'(frm_bits[61:59]), 64'd4);
        update(1'b1, 2'd0, 21'h00104);
        send(2'd0, 2'd0, 21'h00004, 3'd1, 1'b0, 32'h0, "R4 offset -256");
        chk("R4 -256 field", 64'(frm_bits[57:49]), 64'h100);
        send(2'd0, 2'd0, 21'h00003, 3'd1, 1'b0, 32'h0, "R5 offset -257");
        chk("R5 -257 opcode", 64'(frm_bits[61:59]), 64'd4);
        send(2'd0, 2'd2, 21'h00104, 3'd1, 1'b0, 32'h0, "R5 other id");
        chk("R5 other id opcode", 64'(frm_bits[61:59]), 64'd4);
        send(2'd0, 2'd0, 21'h00107, 3'd1, 1'b0, 32'h0, "R5 same beats offset");
        chk("R5 same priority", 64'(frm_bits[61:60]), 64'd3);
    endtask

    task automatic t_sizes;
        update(1'b0, 2'd0, 21'h0);
        send(2'd0, 2'd0, 21'h00003, 3'd2, 1'b0, 32'h0, "R6 size2");
        chk("R6 size2 bit0", 64'(frm_bits[37]), 64'd0);
        chk("R6 size2 flag", 64'(frm_bits[36]), 64'd1);
        send(2'd0, 2'd0, 21'h00006, 3'd4, 1'b0, 32'h0, "R6 size4");
        chk("R6 size4 low bits", 64'(frm_bits[38:37]), 64'd1);
        send(2'd0, 2'd0, 21'h00003, 3'd1, 1'b0, 32'h0, "R6 size1");
        chk("R6 size1 low bits", 64'(frm_bits[38:36]), 64'b110);
    endtask

    task automatic t_writes;
        send(2'd0, 2'd3, 21'h1ABCD, 3'd4, 1'b1, 32'hA1B2C3D4, "R7 write4");
        chk("R7 write4 len", 64'(frm_len), 64'd64);
        chk("R7 write4 dir", 64'(frm_bits[58]), 64'd0);
        chk("R7 write4 data", 64'(frm_bits[35:4]), 64'hA1B2C3D4);
        send(2'd0, 2'd3, 21'h1ABCD, 3'd1, 1'b1, 32'hFFFFFF5A, "R7 write1");
        chk("R7 write1 len", 64'(frm_len), 64'd40);
        chk("R7 write1 data", 64'(frm_bits[35:28]), 64'h5A);
    endtask

    task automatic t_link_cmds;
        send(2'd1, 2'd3, 21'h0, 3'd1, 1'b0, 32'h0, "R8 busy poll");
        chk("R8 busy poll len", 64'(frm_len), 64'd9);
        chk("R8 busy poll head", 64'(frm_bits[63:59]), 64'b11010);
        send(2'd2, 2'd1, 21'h0, 3'd1, 1'b0, 32'h0, "R8 error poll");
        chk("R8 error poll head", 64'(frm_bits[63:59]), 64'b01011);
        send(2'd3, 2'd2, 21'h0, 3'd1, 1'b0, 32'h0, "R8 terminate");
        chk("R8 terminate len", 64'(frm_len), 64'd12);
        chk("R8 terminate head", 64'(frm_bits[63:56]), 64'hBF);
        chk("R9 tail zero", frm_bits << 12, 64'd0);
    endtask

    task automatic t_invalidate;
        update(1'b1, 2'd1, 21'h00400);
        @(negedge clk);
        req_valid = 1; req_kind = 2'd0; req_id = 2'd1; req_addr = 21'h00400;
        req_size = 3'd1; req_write = 0; req_wdata = '0;
        upd_valid = 1; upd_ok = 0; upd_id = 2'd1; upd_addr = 21'h0;
        model_frame(2'd0, 2'd1, 21'h00400, 3'd1, 1'b0, 32'h0);
        @(negedge clk);
        req_valid = 0; upd_valid = 0; m_valid = 0;
        chk("R10 same-cycle uses old record", frm_bits, e_bits);
        chk("R10 same-cycle len", 64'(frm_len), 64'd12);
        send(2'd0, 2'd1, 21'h00400, 3'd1, 1'b0, 32'h0, "R10 after clear");
        chk("R10 cleared -> abs", 64'(frm_bits[61:59]), 64'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_absolute();
        t_same();
        t_offset_limits();
        t_sizes();
        t_writes();
        t_link_cmds();
        t_invalidate();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule